// File: doc/BRIEF.md
# Single-Wire Smart-Card Transceiver with Parity Error Handshake

This block is a character-level serial transceiver for a smart-card link. Transmit and receive share one wire that is pulled high outside the chip. The block never drives that wire high. It either pulls the wire low or lets it float. A character is a low start bit, eight data bits with the least significant bit first, an even parity bit and a high stop bit. Every bit lasts `OSR` pulses of an oversampling tick input, and that tick comes from elsewhere.

When error signalling is enabled and a received character fails its parity check, the receiver pulls the wire low for the stop-bit time. This tells the card that the character was bad. Reading the receive buffer ends that pull at once. When the block sends a character, it samples the wire when the stop bit ends and keeps the level as a "card rejected" status bit.

Software-style access is a write strobe with a byte for transmit and a read strobe for the receive buffer. Status comes out as plain flag outputs, and each direction has a one-cycle completion pulse.

Top module: `scard_uart`

## Requirements
- R1: The block only ever pulls the shared wire low. `line_drive_low` = 1 means pull low and 0 means release. After reset the wire is released and `tx_busy`, `rx_ready`, `parity_err`, `overrun` and `card_nack` are all 0.
- R2: A transmitted frame is 11 bits, each `OSR` ticks long, in this order:
  - one low start bit;
  - the data bits, bit 0 first;
  - a parity bit that is 1 exactly when the data holds an odd number of ones;
  - a released stop bit.
- R3: A write strobe while `tx_busy` = 0 starts a frame, and `tx_busy` becomes 1 on the next clock. A write while `tx_busy` = 1 is ignored and does not change the frame in flight.
- R4: `irq_tx_done` pulses for one clock when the stop bit ends, and `tx_busy` drops at the same edge. At that moment `card_nack` takes the inverted wire level, so a low wire gives 1. `card_nack` returns to 0 when the next frame starts.
- R5: The receiver starts on a high-to-low change of the wire. It accepts the start bit only if the wire is still low half a bit later. After that it samples each bit in its middle, so short glitches near bit edges have no effect.
- R6: When the parity bit has been sampled, `irq_rx_done` pulses and `rx_ready` becomes 1. `rx_data` then holds the byte. `parity_err` is 1 if the data and parity bit together hold an odd number of ones. This happens even when the parity is wrong.
- R7: The receiver pulls the wire low during the stop-bit period only when `err_sig_en` = 1 and `parity_err` is set. Otherwise the wire stays released.
- R8: A read strobe while the error pull is active releases the wire in the same cycle. At the next edge it clears `parity_err` and `rx_ready`.
- R9: If no read arrives, the error pull lasts at most one bit period and then stops. `parity_err` stays set until the buffer is read.
- R10: `overrun` is set when a character completes while `rx_ready` is still 1 and no read happens in that cycle. `rx_data` then holds the newer byte. A read clears `rx_ready`, `parity_err` and `overrun`.
- R11: The receiver does not start a character while the transmitter is busy. The block's own transmission, or a card's reply during it, never sets `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, `OSR` per bit |
| wr_en | input | 1 | Transmit write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Receive buffer read strobe |
| err_sig_en | input | 1 | Enables the parity error pull on reception |
| line_in | input | 1 | Sensed level of the shared wire |
| line_drive_low | output | 1 | 1 pulls the shared wire low |
| rx_data | output | DATA_W | Receive buffer |
| rx_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Last character failed parity |
| overrun | output | 1 | A character was overwritten unread |
| tx_busy | output | 1 | Transmitter sending a frame |
| card_nack | output | 1 | Wire was low at the end of the last transmitted stop bit |
| irq_tx_done | output | 1 | One-cycle pulse at the end of a transmitted frame |
| irq_rx_done | output | 1 | One-cycle pulse when a character is received |

## Verification
The properties assume the following about the inputs:
- Frames on the wire keep the bit period that `os_tick` defines.
- `err_sig_en` does not change within a character.
- `os_tick` is never asserted for two clocks in a row.

The bench drives the tick every second clock and changes the card's wire level only on whole-clock boundaries, a whole number of bit periods apart. It holds the enable fixed for each received character. It waits for the wire to go idle before starting the next one, and it never writes a transmit byte while a character is arriving.

// File: rtl/scu_pkg.sv
package scu_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_GAP,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/scu_sync.sv
module scu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/scu_tx.sv
module scu_tx #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line,
  output logic              tx_busy,
  output logic              tx_drive,
  output logic              tx_done,
  output logic              card_nack
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(OSR);
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  // stop(1) | even parity | data | start(0); bit 0 leaves first
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {1'b1, ^d, d, 1'b0};
  endfunction

  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      cnt;
  logic [IDX_W-1:0]      idx;
  logic                  last_tick;

  assign last_tick = os_tick && tx_busy && (cnt == FULL_M1);
  assign tx_done   = last_tick && (idx == IDX_LAST);
  assign tx_drive  = tx_busy && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      cnt       <= '0;
      idx       <= '0;
      tx_busy   <= 1'b0;
      card_nack <= 1'b0;
    end else if (wr_en && !tx_busy) begin
      shreg     <= build_frame(wr_data);
      cnt       <= '0;
      idx       <= '0;
      tx_busy   <= 1'b1;
      card_nack <= 1'b0;
    end else if (os_tick && tx_busy) begin
      if (cnt == FULL_M1) begin
        cnt <= '0;
        if (idx == IDX_LAST) begin
          tx_busy   <= 1'b0;
          card_nack <= !line;
        end else begin
          shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
          idx   <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scu_rx.sv
module scu_rx
  import scu_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              line,
  input  logic              tx_busy,
  input  logic              err_sig_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              parity_err,
  output logic              overrun,
  output logic              rx_done,
  output logic              rx_start,
  output logic              err_drive
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(OSR / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  // even parity over data plus parity bit: any odd count is an error
  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic p);
    return (^d) ^ p;
  endfunction

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              line_prev;
  logic              cnt_full;
  logic              cnt_half;

  assign cnt_full = (cnt == FULL_M1);
  assign cnt_half = (cnt == HALF_M1);
  assign rx_start = os_tick && (state == RX_IDLE) && line_prev && !line && !tx_busy;
  assign rx_done  = os_tick && (state == RX_PAR) && cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      line_prev <= 1'b1;
      err_drive <= 1'b0;
    end else begin
      if (os_tick) begin
        line_prev <= line;
        unique case (state)
          RX_IDLE: begin
            if (rx_start) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt_half) begin
              cnt <= '0;
              idx <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt_full) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              idx   <= idx + 1'b1;
              if (idx == IDX_LAST) state <= RX_PAR;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt_full) begin
              cnt   <= '0;
              state <= RX_GAP;
            end else cnt <= cnt + 1'b1;
          end
          RX_GAP: begin
            if (cnt_half) begin
              cnt       <= '0;
              state     <= RX_STOP;
              err_drive <= parity_err && err_sig_en && !rd_en;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt_full) begin
              cnt       <= '0;
              state     <= RX_IDLE;
              err_drive <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
      if (rd_en) err_drive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
    end else if (rx_done) begin
      rx_data    <= shreg;
      rx_ready   <= 1'b1;
      parity_err <= parity_bad(shreg, line);
      overrun    <= (rx_ready || overrun) && !rd_en;
    end else if (rd_en) begin
      rx_ready   <= 1'b0;
      parity_err <= 1'b0;
      overrun    <= 1'b0;
    end
  end
endmodule

// File: rtl/scard_uart.sv
module scard_uart #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              err_sig_en,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              parity_err,
  output logic              overrun,
  output logic              tx_busy,
  output logic              card_nack,
  output logic              irq_tx_done,
  output logic              irq_rx_done
);
  logic line_s;
  logic tx_drive;
  logic tx_done;
  logic rx_done;
  logic rx_start;
  logic rx_err_drive;

  scu_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (line_in),
    .sync_out (line_s)
  );

  scu_tx #(.OSR(OSR), .DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .line      (line_s),
    .tx_busy   (tx_busy),
    .tx_drive  (tx_drive),
    .tx_done   (tx_done),
    .card_nack (card_nack)
  );

  scu_rx #(.OSR(OSR), .DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .line       (line_s),
    .tx_busy    (tx_busy),
    .err_sig_en (err_sig_en),
    .rd_en      (rd_en),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .parity_err (parity_err),
    .overrun    (overrun),
    .rx_done    (rx_done),
    .rx_start   (rx_start),
    .err_drive  (rx_err_drive)
  );

  // a read ends the error pull combinationally, in the cycle it arrives
  assign line_drive_low = tx_drive || (rx_err_drive && !rd_en);
  assign irq_tx_done    = tx_done;
  assign irq_rx_done    = rx_done;
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int OSR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic wr_en,
  input logic rd_en,
  input logic line_drive_low,
  input logic tx_busy,
  input logic rx_ready,
  input logic parity_err,
  input logic overrun,
  input logic irq_tx_done,
  input logic irq_rx_done,
  input logic rx_start,
  input logic rx_err_drive
);
  localparam int TW = $clog2(OSR) + 2;
  logic [TW-1:0] err_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_ticks <= '0;
    else if (!rx_err_drive) err_ticks <= '0;
    else if (os_tick)      err_ticks <= err_ticks + 1'b1;
  end

  p_open_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> (tx_busy || rx_err_drive));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_busy) |=> tx_busy);

  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !irq_tx_done) |=> tx_busy);

  p_tx_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_done |=> (!irq_tx_done && !tx_busy));

  p_rx_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_done |=> rx_ready);

  p_err_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_drive && !rd_en) |-> parity_err);

  p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err_drive && rd_en) |=> !rx_err_drive);

  p_err_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_drive |-> (err_ticks <= TW'(OSR)));

  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx_done && rx_ready && !rd_en) |=> overrun);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !irq_rx_done) |=> (!rx_ready && !parity_err && !overrun));

  p_no_rx_in_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !rx_start);
endmodule

bind scard_uart scu_checker #(.OSR(OSR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .os_tick        (os_tick),
  .wr_en          (wr_en),
  .rd_en          (rd_en),
  .line_drive_low (line_drive_low),
  .tx_busy        (tx_busy),
  .rx_ready       (rx_ready),
  .parity_err     (parity_err),
  .overrun        (overrun),
  .irq_tx_done    (irq_tx_done),
  .irq_rx_done    (irq_rx_done),
  .rx_start       (rx_start),
  .rx_err_drive   (rx_err_drive)
);

// File: tb/sim_scard_uart.sv
module sim_scard_uart;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 16;
  localparam int TDIV       = 2;
  localparam int BIT_CLKS   = OSR * TDIV;

  typedef struct packed {
    logic [7:0] data;
    logic       flip;
    logic       en;
    logic       rd_mid;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b0, 1'b1, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 1'b0},
    '{8'h01, 1'b1, 1'b0, 1'b0},
    '{8'hFE, 1'b1, 1'b1, 1'b1},
    '{8'h80, 1'b0, 1'b0, 1'b0},
    '{8'h7F, 1'b1, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       err_sig_en = 1'b0;
  logic       card_low = 1'b0;
  logic       line_in;
  logic       line_drive_low;
  logic [7:0] rx_data;
  logic       rx_ready, parity_err, overrun, tx_busy, card_nack;
  logic       irq_tx_done, irq_rx_done;

  int n_chk = 0;
  int n_bad = 0;
  int tx_irqs = 0;
  int rx_irqs = 0;
  int tick_phase = 0;
  bit finished = 1'b0;

  assign line_in = !(line_drive_low || card_low);

  scard_uart #(.OSR(OSR), .DATA_W(8)) u0 (
    .clk, .rst_n, .os_tick, .wr_en, .wr_data, .rd_en, .err_sig_en, .line_in,
    .line_drive_low, .rx_data, .rx_ready, .parity_err, .overrun, .tx_busy,
    .card_nack, .irq_tx_done, .irq_rx_done
  );

  always #(CLK_PERIOD/2) clk = !clk;

  always @(negedge clk) begin
    tick_phase <= (tick_phase + 1) % TDIV;
    os_tick    <= (tick_phase == TDIV - 1);
  end

  always @(posedge clk) begin
    if (irq_tx_done) tx_irqs++;
    if (irq_rx_done) rx_irqs++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    return ($countones(d) % 2) == 1;
  endfunction

  // card sends start, data, parity; returns at the start of its stop bit
  task automatic card_send(input logic [7:0] d, input logic flip, input logic glitch);
    logic [9:0] bits;
    bits = {even_bit(d) ^ flip, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        if (glitch && (c < 3 || c >= BIT_CLKS - 3)) card_low = bits[i];
        else card_low = !bits[i];
        @(negedge clk);
      end
    end
    card_low = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tx_run(input logic [7:0] d, input logic nack);
    logic [10:0] fr;
    int irq0;
    fr = {1'b1, even_bit(d), d, 1'b0};
    irq0 = tx_irqs;
    wr_data = d;
    wr_en = 1'b1;
    for (int c = 1; c <= 11 * BIT_CLKS + 20; c++) begin
      @(negedge clk);
      if (c == 1) wr_en = 1'b0;
      if (c == 2) begin
        chk("R3 busy after write", tx_busy, 1'b1);
        chk("R4 nack cleared on start", card_nack, 1'b0);
      end
      if (c == 100) begin wr_data = ~d; wr_en = 1'b1; end
      if (c == 101) wr_en = 1'b0;
      if (nack && c == 10 * BIT_CLKS + 4) card_low = 1'b1;
      if (c == 11 * BIT_CLKS + 12) card_low = 1'b0;
      for (int k = 0; k < 11; k++)
        if (c == k * BIT_CLKS + 17)
          chk((k == 0) ? "R2 start bit" : (k == 10) ? "R2 stop bit" : "R2 R3 frame bit",
              line_drive_low, (k == 10) ? 1'b0 : !fr[k]);
    end
    chk("R4 one done pulse", tx_irqs - irq0, 1);
    chk("R4 card nack", card_nack, nack);
    chk("R4 busy dropped", tx_busy, 1'b0);
    chk("R11 no echo received", rx_ready, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset drive", line_drive_low, 1'b0);
    chk("R1 reset busy", tx_busy, 1'b0);
    chk("R1 reset ready", rx_ready, 1'b0);
    chk("R1 reset flags", {parity_err, overrun, card_nack}, 3'b000);
    repeat (10) @(negedge clk);

    foreach (VECS[i]) begin
      err_sig_en = VECS[i].en;
      card_send(VECS[i].data, VECS[i].flip, 1'b0);
      chk("R6 ready", rx_ready, 1'b1);
      chk("R6 data", rx_data, VECS[i].data);
      chk("R6 parity flag", parity_err, VECS[i].flip);
      repeat (16) @(negedge clk);
      chk("R7 stop drive", line_drive_low, VECS[i].flip && VECS[i].en);
      if (VECS[i].rd_mid) begin
        rd_en = 1'b1;
        #1;
        chk("R8 release same cycle", line_drive_low, 1'b0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 flags cleared", {rx_ready, parity_err}, 2'b00);
        repeat (40) @(negedge clk);
      end else begin
        repeat (28) @(negedge clk);
        chk("R9 drive ended", line_drive_low, 1'b0);
        chk("R9 flag kept", parity_err, VECS[i].flip);
        do_read();
        chk("R10 read clears", {rx_ready, parity_err, overrun}, 3'b000);
        repeat (20) @(negedge clk);
      end
    end

    err_sig_en = 1'b1;
    card_send(8'h11, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    card_send(8'h22, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    chk("R10 overrun set", overrun, 1'b1);
    chk("R10 newer byte kept", rx_data, 8'h22);
    do_read();
    chk("R10 overrun cleared", {rx_ready, overrun}, 2'b00);
    repeat (20) @(negedge clk);

    card_send(8'h96, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    chk("R5 glitchy edges data", rx_data, 8'h96);
    chk("R5 glitchy edges parity", parity_err, 1'b0);
    do_read();
    repeat (20) @(negedge clk);

    begin
      int r0;
      r0 = rx_irqs;
      card_low = 1'b1;
      repeat (4) @(negedge clk);
      card_low = 1'b0;
      repeat (12 * BIT_CLKS) @(negedge clk);
      chk("R5 false start rejected", rx_irqs - r0, 0);
      chk("R5 no ready after glitch", rx_ready, 1'b0);
    end

    tx_run(8'h5A, 1'b0);
    repeat (20) @(negedge clk);
    tx_run(8'hC3, 1'b1);
    repeat (20) @(negedge clk);
    tx_run(8'h0F, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule